// File: doc/BRIEF.md
# Misprediction-Driven Fetch Gating Controller

This controller sits next to the fetch stage of a speculative pipeline and pauses instruction fetch when branch prediction is performing poorly. This saves the energy that would otherwise go into fetching down paths that are likely to be wrong. Each resolved branch reports whether its prediction was wrong. The controller keeps a saturating tally of these misses.

When the tally rises strictly above a programmable threshold, the controller drops the fetch enable for a programmable number of cycles. It then raises fetch again and starts the tally over from zero. A hold-off length of zero turns the mechanism off.

The threshold and hold-off inputs are sampled only when a gating interval begins. Changing them in the middle of an interval therefore affects only later intervals. Miss reports that arrive while fetch is paused are dropped.

Top module: `fetch_gate_ctrl`

## Requirements
- R1: While rst_ni is low, and on its release, the miss tally is zero, fetch_en_o is 1 and gate_active_o is 0.
- R2: A cycle with br_valid_i=1 and br_mispred_i=1 outside a gating interval adds one to the miss tally. A cycle with br_valid_i=1 and br_mispred_i=0 leaves the tally unchanged.
- R3: The miss tally saturates at 2^CNT_W-1 and never wraps to zero.
- R4: A gating interval begins on the clock edge after the registered tally is strictly greater than thresh_i, provided holdoff_i is non-zero. A tally equal to thresh_i never starts one. On that starting edge, a miss report in the same cycle is not counted.
- R5: During a gating interval, fetch_en_o is 0 and gate_active_o is 1. Outside an interval, fetch_en_o is 1 and gate_active_o is 0.
- R6: A gating interval lasts exactly k cycles, where k is holdoff_i sampled on its starting edge. On the next edge fetch_en_o returns to 1 and the miss tally is cleared to zero.
- R7: Miss reports received during a gating interval do not add to the tally.
- R8: While holdoff_i is zero, no gating interval begins and fetch_en_o stays 1.
- R9: Values of thresh_i and holdoff_i that change during a gating interval do not alter the length of that interval. They apply from the next trigger onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | A branch resolved this cycle |
| br_mispred_i | input | 1 | The resolved branch was mispredicted |
| thresh_i | input | CNT_W | Miss threshold; gating needs the tally strictly above it |
| holdoff_i | input | HOLD_W | Fetch pause length in cycles; 0 disables gating |
| fetch_en_o | output | 1 | Fetch may proceed |
| gate_active_o | output | 1 | A gating interval is in progress |

## Verification
The bench targets several boundary cases. The first is a tally exactly equal to the threshold: a design that compares with greater-or-equal would pause fetch one miss too early. The second is a burst of miss reports during an interval, which must leave the tally at zero afterwards; a design that counts them would re-gate too soon. The bench also sweeps a long run of misses with the threshold one below the maximum. A wrapping tally would fall back to zero and fail to trigger once the hold-off is enabled. Finally, it changes the threshold and hold-off in the middle of an interval and checks the interval length, and it checks a zero hold-off, where a design that gates anyway would pause fetch permanently or for a wrapped count.

// File: rtl/fetch_gate_pkg.sv
package fetch_gate_pkg;
  localparam int unsigned DEF_CNT_W  = 4;
  localparam int unsigned DEF_HOLD_W = 6;
endpackage

// File: rtl/miss_counter.sv
module miss_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (inc_i && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_sat_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));

  p_inc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_idle_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned HOLD_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HOLD_W-1:0] load_val_i,
  output logic              busy_o,
  output logic              last_o
);
  logic [HOLD_W-1:0] rem_q;

  // Length is captured once at load; later input changes are not seen.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rem_q <= '0;
    else if (load_i)       rem_q <= load_val_i;
    else if (rem_q != '0)  rem_q <= rem_q - 1'b1;
  end

  assign busy_o = (rem_q != '0);
  assign last_o = (rem_q == HOLD_W'(1));

  p_countdown_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (rem_q == $past(rem_q) - 1'b1));

  p_load_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rem_q == $past(load_val_i)));
endmodule

// File: rtl/fetch_gate_ctrl.sv
module fetch_gate_ctrl
  import fetch_gate_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned HOLD_W = DEF_HOLD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              br_valid_i,
  input  logic              br_mispred_i,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic [HOLD_W-1:0] holdoff_i,
  output logic              fetch_en_o,
  output logic              gate_active_o
);
  logic [CNT_W-1:0] miss_cnt;
  logic             gating, gate_last;
  logic             trigger, miss_inc;

  assign trigger  = !gating && (miss_cnt > thresh_i) && (holdoff_i != '0);
  assign miss_inc = br_valid_i && br_mispred_i && !gating && !trigger;

  miss_counter #(.CNT_W(CNT_W)) u_miss_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (miss_inc),
    .clr_i  (gate_last),
    .cnt_o  (miss_cnt)
  );

  hold_timer #(.HOLD_W(HOLD_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (trigger),
    .load_val_i (holdoff_i),
    .busy_o     (gating),
    .last_o     (gate_last)
  );

  assign fetch_en_o    = !gating;
  assign gate_active_o = gating;

  p_trigger_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gating && miss_cnt > thresh_i && holdoff_i != '0) |=> !fetch_en_o);

  p_no_trigger_eq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gating && miss_cnt <= thresh_i) |=> fetch_en_o);

  p_zero_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gating && holdoff_i == '0) |=> fetch_en_o);

  p_ignore_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gating && !gate_last) |=> $stable(miss_cnt));

  p_resume_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_last |=> (fetch_en_o && miss_cnt == '0));

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (fetch_en_o && !gate_active_o));
endmodule

// File: tb/fetch_gate_ctrl_tb_top.sv
module fetch_gate_ctrl_tb_top;
  localparam int CW = 4;
  localparam int HW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bv = 1'b0, bm = 1'b0;
  logic [CW-1:0] th = '0;
  logic [HW-1:0] ho = '0;
  logic          fe, ga;

  int n_chk = 0, n_err = 0;
  int m_cnt = 0, m_hold = 0;

  always #10 clk = ~clk;

  fetch_gate_ctrl #(.CNT_W(CW), .HOLD_W(HW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(bv), .br_mispred_i(bm),
    .thresh_i(th), .holdoff_i(ho), .fetch_en_o(fe), .gate_active_o(ga)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model advanced once per clock edge from the requirements.
  task automatic model_step();
    if (m_hold > 0) begin
      if (m_hold == 1) m_cnt = 0;
      m_hold--;
    end else if (m_cnt > int'(th) && ho != '0) begin
      m_hold = int'(ho);
    end else if (bv && bm) begin
      if (m_cnt < CMAX) m_cnt++;
    end
  endtask

  task automatic cyc(string tag, logic v, logic m);
    bv = v; bm = m;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, fe, (m_hold == 0));
    chk(tag, ga, (m_hold != 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #5;
    chk("R1", fe, 1'b1);
    chk("R1", ga, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", fe, 1'b1);

    // R2/R4: threshold 3, equal tally does not trigger
    th = 4'd3; ho = 6'd5;
    for (int i = 0; i < 3; i++) begin
      cyc("R2", 1'b1, 1'b1);
      cyc("R2", 1'b1, 1'b0);
    end
    cyc("R4", 1'b0, 1'b0);
    chk("R4", fe, 1'b1);
    cyc("R4", 1'b1, 1'b1);
    cyc("R4", 1'b0, 1'b0);
    chk("R5", fe, 1'b0);
    // R7/R9: strobes and register changes mid-interval
    th = 4'd0; ho = 6'd40;
    for (int i = 0; i < 4; i++) cyc("R9", 1'b1, 1'b1);
    cyc("R6", 1'b0, 1'b0);
    chk("R6", fe, 1'b1);
    th = 4'd3; ho = 6'd5;
    for (int i = 0; i < 3; i++) cyc("R7", 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) cyc("R7", 1'b0, 1'b0);
    chk("R7", fe, 1'b1);
    cyc("R4", 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) cyc("R6", 1'b0, 1'b0);

    // R8: zero hold-off never gates
    ho = '0; th = 4'd1;
    for (int i = 0; i < 12; i++) cyc("R8", 1'b1, 1'b1);
    chk("R8", fe, 1'b1);

    // R3: 16 more misses, saturated tally must exceed 14 once enabled
    th = 4'(CMAX - 1);
    for (int i = 0; i < 16; i++) cyc("R3", 1'b1, 1'b1);
    ho = 6'd3;
    cyc("R3", 1'b0, 1'b0);
    chk("R3", ga, 1'b1);
    for (int i = 0; i < 4; i++) cyc("R3", 1'b0, 1'b0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) th = CW'($urandom_range(0, 5));
      if ($urandom_range(0, 15) == 0) ho = HW'($urandom_range(0, 9));
      cyc("R5", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) != 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule